// File: doc/BRIEF.md
# Burst Address Sequencer for Synchronous SRAM

This block supplies the word address that a synchronous burst SRAM sends to its array. A burst begins when one of two start strobes is sampled on a rising clock edge. One strobe comes from the processor side and the other from the memory controller side. At a burst start the block captures the full external address. The upper bits stay fixed for the rest of the burst. The two low bits are produced by a 2-bit beat counter, which steps only on cycles where the advance input is high.

The low bits follow one of two sequences, chosen by a mode input. In linear order the beat count is added to the starting offset, modulo four. In interleaved order the starting offset is XORed with the beat count. Either way, a burst stays inside its aligned block of four words. A new address can be loaded on every cycle, so bursting is optional.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is released, addr_out is all zeros.
- R2: When strt_ctl is high at a rising edge, addr_in is captured whatever the value of ce. After that edge, addr_out equals addr_in (beat count 0).
- R3: strt_cpu starts a burst only when ce is high at the same edge. With ce low and strt_ctl low, strt_cpu has no effect and addr_out is held.
- R4: When no start occurs and adv is high at an edge, the beat count increments. When no start occurs and adv is low, addr_out is held.
- R5: With order_il low (linear), addr_out[1:0] equals (start offset + beat count) mod 4.
- R6: With order_il high (interleaved), addr_out[1:0] equals start offset XOR beat count.
- R7: During a burst, addr_out[AW-1:2] never changes. After four advances, addr_out returns to the starting address, with no carry into the upper bits.
- R8: A start has priority over adv at the same edge: the beat count becomes 0. Loads on consecutive cycles each take effect.
- R9: order_il acts on addr_out without a clock edge and leaves the beat count unchanged. Switching order mid-burst re-maps the current beat at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_in | input | AW | External word address |
| ce | input | 1 | Chip enable; qualifies strt_cpu |
| strt_cpu | input | 1 | Processor-side burst start |
| strt_ctl | input | 1 | Controller-side burst start |
| adv | input | 1 | Advance the beat count |
| order_il | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_out | output | AW | Address presented to the array |

## Verification
A burst start and an advance can both be asserted at the same edge. The bench provokes this by raising adv together with either strobe, in the middle of a running burst. It then expects the freshly loaded address with beat zero, not a stepped one. A change of order_il can also land mid-burst alongside an advance. The bench checks that the result uses the new order applied to the incremented beat.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_in,
  input  logic          ce,
  input  logic          strt_cpu,
  input  logic          strt_ctl,
  input  logic          adv,
  input  logic          order_il,
  output logic [AW-1:0] addr_out
);
  localparam int UW = AW - 2;

  logic [UW-1:0] upper_q;
  logic [1:0]    off_q;
  logic [1:0]    beat_q;
  logic          load;
  logic [1:0]    low;

  assign load = (strt_cpu && ce) || strt_ctl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upper_q <= '0;
      off_q   <= '0;
      beat_q  <= '0;
    end else if (load) begin
      upper_q <= addr_in[AW-1:2];
      off_q   <= addr_in[1:0];
      beat_q  <= '0;
    end else if (adv) begin
      beat_q  <= beat_q + 2'd1;
    end
  end

  assign low      = order_il ? (off_q ^ beat_q) : (off_q + beat_q);
  assign addr_out = {upper_q, low};
endmodule

module burst_addr_seq_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr_in,
  input logic          ce,
  input logic          strt_cpu,
  input logic          strt_ctl,
  input logic          adv,
  input logic          order_il,
  input logic [AW-1:0] addr_out
);
  AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    strt_ctl |=> addr_out[AW-1:2] == $past(addr_in[AW-1:2])); // R2

  AST_CPU_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (strt_cpu && !ce && !strt_ctl && !adv) |=> ($stable(addr_out) || !$stable(order_il))); // R3

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (!strt_ctl && !(strt_cpu && ce)) |=> $stable(addr_out[AW-1:2])); // R7

  AST_LIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!strt_ctl && !(strt_cpu && ce) && adv && !order_il) |=>
      (order_il || addr_out[1:0] == $past(addr_out[1:0]) + 2'd1)); // R5

  AST_START_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (strt_ctl && adv) |=> addr_out == $past(addr_in)); // R8
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
  localparam int AW = 20;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [AW-1:0] addr_in = '0;
  logic          ce = 0, strt_cpu = 0, strt_ctl = 0, adv = 0, order_il = 1;
  logic [AW-1:0] addr_out;

  int checks = 0, errors = 0;
  logic [AW-1:0] exp_q[$];
  string         tag_q[$];

  logic [AW-3:0] m_up = '0;
  logic [1:0]    m_off = '0, m_beat = '0;

  always #2 clk = ~clk;

  burst_addr_seq #(.AW(AW)) u0 (.*);

  function automatic logic [AW-1:0] model_addr(logic il);
    logic [1:0] lo;
    lo = il ? (m_off ^ m_beat) : 2'(m_off + m_beat);
    return {m_up, lo};
  endfunction

  task automatic check(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: addr_out=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic [AW-1:0] a, logic e, logic sc, logic sk,
                      logic ad, logic il);
    @(negedge clk);
    addr_in = a; ce = e; strt_cpu = sc; strt_ctl = sk; adv = ad; order_il = il;
    @(posedge clk);
    if ((sc && e) || sk) begin
      m_up = a[AW-1:2]; m_off = a[1:0]; m_beat = 2'd0;
    end else if (ad) begin
      m_beat = m_beat + 2'd1;
    end
    #1;
    exp_q.push_back(model_addr(il));
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) check(tag_q.pop_front(), addr_out, exp_q.pop_front());
    end
  end

  initial begin : watchdog
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: expired, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", addr_out, '0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    exp_q.push_back('0); tag_q.push_back("R1 after release");

    for (int il = 0; il < 2; il++) begin
      for (int s = 0; s < 4; s++) begin
        logic [AW-1:0] base;
        base = AW'(20'h5A3C0 + s + il * 16);
        step(il ? "R2 R6 ctl load" : "R2 R5 ctl load", base, 0, 0, 1, 0, il[0]);
        for (int b = 0; b < 4; b++)
          step(il ? "R4 R6 R7 interleaved beat" : "R4 R5 R7 linear beat",
               base, 0, 0, 0, 1, il[0]);
        step("R4 hold", base, 0, 0, 0, 0, il[0]);
      end
    end

    step("R3 cpu load with ce", 20'h12345, 1, 1, 0, 0, 0);
    step("R4 adv", 20'h0, 0, 0, 0, 1, 0);
    step("R3 cpu ignored ce low", 20'hFFFFF, 0, 1, 0, 0, 0);
    step("R3 cpu ignored ce low adv", 20'hABCDE, 0, 1, 0, 1, 0);
    step("R8 cpu start beats adv", 20'h0F0F2, 1, 1, 0, 1, 1);
    step("R4 adv", 20'h0, 0, 0, 0, 1, 1);
    step("R8 ctl start beats adv", 20'h33331, 0, 0, 1, 1, 0);
    step("R8 both strobes", 20'h44443, 1, 1, 1, 1, 0);
    for (int k = 0; k < 6; k++)
      step("R8 back-to-back loads", AW'(20'h80000 + k * 7), k[0], 1, ~k[0], 0, 1);
    step("R9 start", 20'h77771, 0, 0, 1, 0, 0);
    step("R9 adv linear", 20'h0, 0, 0, 0, 1, 0);
    step("R9 order flip hold", 20'h0, 0, 0, 0, 0, 1);
    step("R9 order flip with adv", 20'h0, 0, 0, 0, 1, 0);
    step("R9 adv interleaved", 20'h0, 0, 0, 0, 1, 1);
    step("R7 wrap", 20'h0, 0, 0, 0, 1, 1);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule